// File: doc/BRIEF.md
# Transmit/Receive-State Driven GPIO Bank

This block is an 11-pin general-purpose I/O bank for a radio front end. Each pin can be driven by a value that software writes, or by the transceiver's current activity. When a pin follows the activity, one of four per-state value registers supplies its level. The four states are idle, receive only, transmit only and both at once. The `rx_active` and `tx_active` inputs pick the state on every clock.

Software uses a small write/read strobe interface. Every write carries a per-bit mask, so several agents can own different pins of one register without read-modify-write races. A direction register sets the output enable of each pin. A readback address returns the synchronised level seen on every pin, so a driven pin looped back to an input can be checked.

Top module: `atr_gpio_bank`

## Requirements
- R1: After a synchronous reset every stored register is 0, which means all pins are inputs under manual control. `pin_oe`, `pin_out` and `rd_data` are then all zero.
- R2: A write changes only the bits set in `wr_mask`, loading them from `wr_data`. Every other bit keeps its previous contents.
- R3: The address map is 0 control-select, 1 direction, 2 idle values, 3 receive values, 4 transmit values, 5 duplex values, 6 manual output, 7 pin readback. A read strobe at a clock edge loads `rd_data` with the addressed contents. `rd_data` holds between strobes.
- R4: Address 7 returns the pin levels through a two-flop synchroniser, so it lags `pin_in` by two clocks. A write to address 7 changes no register.
- R5: The state is taken as {tx_active, rx_active}. 00 selects the idle values, 01 the receive values, 10 the transmit values and 11 the duplex values.
- R6: A pin whose control-select bit is 1 takes the selected state value. A pin whose bit is 0 takes the manual output bit.
- R7: `pin_oe` equals the direction register, registered, so a pin with direction 0 is never enabled whatever its other settings are.
- R8: `pin_out` and `pin_oe` are registered. They change one clock after a change of `rx_active`/`tx_active` is sampled, and two clocks after the write strobe.
- R9: A read and a write to the same address in the same cycle return the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 11 | Write value |
| wr_mask | input | 11 | Per-bit write enable |
| rd_data | output | 11 | Registered read value |
| rx_active | input | 1 | Receive path active |
| tx_active | input | 1 | Transmit path active |
| pin_in | input | 11 | Levels seen on the pins |
| pin_out | output | 11 | Output data to pads |
| pin_oe | output | 11 | Output enables to pads |

## Verification
Two functions can meet in one cycle: a register write and a read of the same address, and a state change together with a write to the value register for the new state. The bench forces both collisions on purpose and also lets them arise in a long random phase. In that phase strobes, masks and state bits change freely. A behavioural model updates on the same edge with old-before-new ordering. It judges every cycle that a same-cycle read returns the old contents. It also judges that the output follows the value register as it stood before the write.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CFG = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_SEL  = 3'd0,
    A_DIR  = 3'd1,
    A_IDLE = 3'd2,
    A_RXV  = 3'd3,
    A_TXV  = 3'd4,
    A_FDX  = 3'd5,
    A_MAN  = 3'd6,
    A_PINS = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RX   = 2'b01,
    ST_TX   = 2'b10,
    ST_FDX  = 2'b11
  } trx_state_e;
endpackage

// File: rtl/atr_gpio_regs.sv
module atr_gpio_regs
  import atr_gpio_pkg::*;
#(
  parameter int W = 11
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [W-1:0]                  wr_data,
  input  logic [W-1:0]                  wr_mask,
  output logic [NUM_CFG-1:0][W-1:0]     cfg_q
);

  // one masked register per address; address 7 has no storage
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        cfg_q[g] <= (cfg_q[g] & ~wr_mask) | (wr_data & wr_mask);
      end
    end
  end

  // R2: bits outside the mask survive a write to the control-select register
  a_r2_mask_keeps: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_SEL) |=>
      ((cfg_q[0] & ~$past(wr_mask)) == ($past(cfg_q[0]) & ~$past(wr_mask))));

  // R4: a write aimed at the readback address leaves storage untouched
  a_r4_pins_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_PINS) |=> $stable(cfg_q));

endmodule

// File: rtl/atr_gpio_sync.sv
module atr_gpio_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;

  // R4: readback trails the pin by exactly two sampling edges
  a_r4_two_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/atr_gpio_outmux.sv
module atr_gpio_outmux
  import atr_gpio_pkg::*;
#(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_active,
  input  logic         tx_active,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] v_idle,
  input  logic [W-1:0] v_rx,
  input  logic [W-1:0] v_tx,
  input  logic [W-1:0] v_fdx,
  input  logic [W-1:0] man,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  trx_state_e   state;
  logic [W-1:0] state_val;
  logic [W-1:0] drive;

  assign state = trx_state_e'({tx_active, rx_active});

  always_comb begin
    unique case (state)
      ST_IDLE: state_val = v_idle;
      ST_RX:   state_val = v_rx;
      ST_TX:   state_val = v_tx;
      default: state_val = v_fdx;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign drive[i] = sel[i] ? state_val[i] : man[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= drive;
      pin_oe  <= dir;
    end
  end

  // R7: no pin is enabled whose direction bit was 0 on the previous edge
  a_r7_input_not_driven: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_oe & ~$past(dir)) == '0));

  // R6: manually owned pins follow the manual register of the previous cycle
  a_r6_manual_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_out & ~$past(sel)) == ($past(man) & ~$past(sel))));

  // R5: an automatic pin in idle takes the idle value
  a_r5_idle_value: assert property (@(posedge clk) disable iff (rst)
    (!rx_active && !tx_active) |=> ((pin_out & $past(sel)) == ($past(v_idle) & $past(sel))));

endmodule

// File: rtl/atr_gpio_bank.sv
module atr_gpio_bank
  import atr_gpio_pkg::*;
#(
  parameter int W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      wr_mask,
  output logic [W-1:0]      rd_data,
  input  logic              rx_active,
  input  logic              tx_active,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  logic [NUM_CFG-1:0][W-1:0] cfg;
  logic [W-1:0]              pins_sync;

  atr_gpio_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .cfg_q   (cfg)
  );

  atr_gpio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  atr_gpio_outmux #(.W(W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .rx_active (rx_active),
    .tx_active (tx_active),
    .sel       (cfg[A_SEL]),
    .dir       (cfg[A_DIR]),
    .v_idle    (cfg[A_IDLE]),
    .v_rx      (cfg[A_RXV]),
    .v_tx      (cfg[A_TXV]),
    .v_fdx     (cfg[A_FDX]),
    .man       (cfg[A_MAN]),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // registered read port; sees contents from before a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (addr == A_PINS) rd_data <= pins_sync;
      else                rd_data <= cfg[addr];
    end
  end

  // R3: read data holds between strobes
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R9: read of the direction register alongside its write returns the old value
  a_r9_read_old: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && addr == A_DIR) |=> (rd_data == $past(cfg[A_DIR])));

endmodule

// File: tb/atr_gpio_bank_tb_top.sv
module atr_gpio_bank_tb_top;
  localparam int W = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wr_data = '0, wr_mask = '0;
  logic [W-1:0] rd_data;
  logic         rx_active = 1'b0, tx_active = 1'b0;
  logic [W-1:0] ext_in = '0;
  logic [W-1:0] pin_in;
  logic [W-1:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  string phase = "R1 reset";

  always #10 clk = ~clk;

  // loopback: driven pins read their own level, others read the outside world
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  atr_gpio_bank #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_data(rd_data),
    .rx_active(rx_active), .tx_active(tx_active),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] m_reg [0:6];
  logic [W-1:0] m_s1, m_s2, m_out, m_oe, m_rd, m_pin_samp;

  always @(negedge clk) m_pin_samp = pin_in;

  always @(posedge clk) begin
    logic [W-1:0] pick;
    if (rst) begin
      for (int k = 0; k < 7; k++) m_reg[k] = '0;
      m_s1 = '0; m_s2 = '0; m_out = '0; m_oe = '0; m_rd = '0;
    end else begin
      case ({tx_active, rx_active})
        2'b00: pick = m_reg[2];
        2'b01: pick = m_reg[3];
        2'b10: pick = m_reg[4];
        default: pick = m_reg[5];
      endcase
      m_out = (m_reg[0] & pick) | (~m_reg[0] & m_reg[6]);
      m_oe  = m_reg[1];
      if (rd_en) m_rd = (addr == 3'd7) ? m_s2 : m_reg[addr];
      m_s2 = m_s1;
      m_s1 = m_pin_samp;
      if (wr_en && addr != 3'd7)
        m_reg[addr] = (m_reg[addr] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " R8 pin_out"}, pin_out, m_out);
      chk({phase, " R7 pin_oe"},  pin_oe,  m_oe);
      chk({phase, " R3 rd_data"}, rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] m);
    @(posedge clk); #2;
    wr_en = 1'b1; addr = a; wr_data = d; wr_mask = m;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    @(posedge clk); #2;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #2;
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic state(input logic tx, input logic rx);
    @(posedge clk); #2;
    tx_active = tx; rx_active = rx;
    @(posedge clk); #2;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pin_oe", pin_oe, '0);
    chk("R1 reset pin_out", pin_out, '0);
    rd(3'd0, v); chk("R1 reset sel reg", v, '0);
    rd(3'd1, v); chk("R1 reset dir reg", v, '0);

    phase = "R3 config";
    wr(3'd0, 11'h00F, 11'h7FF);
    wr(3'd1, 11'h01F, 11'h7FF);
    wr(3'd2, 11'h001, 11'h7FF);
    wr(3'd3, 11'h002, 11'h7FF);
    wr(3'd4, 11'h004, 11'h7FF);
    wr(3'd5, 11'h008, 11'h7FF);
    rd(3'd4, v); chk("R3 tx values readable", v, 11'h004);

    phase = "R2 mask";
    wr(3'd1, 11'h7FF, 11'h400);
    rd(3'd1, v); chk("R2 masked dir write", v, 11'h41F);
    wr(3'd1, 11'h01F, 11'h7FF);
    rd(3'd1, v); chk("R2 dir restored", v, 11'h01F);

    phase = "R5 states";
    state(1'b0, 1'b0); chk("R5 idle", pin_out & 11'h00F, 11'h001);
    state(1'b0, 1'b1); chk("R5 rx only", pin_out & 11'h00F, 11'h002);
    state(1'b1, 1'b0); chk("R5 tx only", pin_out & 11'h00F, 11'h004);
    state(1'b1, 1'b1); chk("R5 duplex", pin_out & 11'h00F, 11'h008);

    phase = "R6 manual";
    state(1'b0, 1'b1);
    wr(3'd6, 11'h011, 11'h011);
    chk("R8 output not yet updated", pin_out & 11'h010, 11'h000);
    @(posedge clk); #2;
    chk("R6 manual bit 4", pin_out & 11'h010, 11'h010);
    chk("R6 automatic bit 0 ignores manual", pin_out & 11'h001, 11'h000);
    chk("R7 oe from dir", pin_oe, 11'h01F);

    phase = "R4 readback";
    ext_in = 11'h7E0;
    repeat (3) @(posedge clk); #2;
    rd(3'd7, v); chk("R4 readback levels", v, 11'h7E0 | 11'h012);
    wr(3'd7, 11'h000, 11'h7FF);
    rd(3'd0, v); chk("R4 write to readback ignored", v, 11'h00F);
    rd(3'd6, v); chk("R4 manual reg intact", v, 11'h011);

    phase = "R9 collide";
    @(posedge clk); #2;
    wr_en = 1'b1; rd_en = 1'b1; addr = 3'd1; wr_data = 11'h000; wr_mask = 11'h001;
    @(posedge clk); #2;
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 same cycle read old", rd_data, 11'h01F);
    rd(3'd1, v); chk("R9 next read new", v, 11'h01E);

    phase = "R5 state with write";
    @(posedge clk); #2;
    wr_en = 1'b1; addr = 3'd4; wr_data = 11'h000; wr_mask = 11'h004;
    tx_active = 1'b1; rx_active = 1'b0;
    @(posedge clk); #2;
    wr_en = 1'b0;
    chk("R8 old tx value used", pin_out & 11'h004, 11'h004);
    @(posedge clk); #2;
    chk("R5 new tx value used", pin_out & 11'h004, 11'h000);

    phase = "R2 random";
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #2;
      wr_en     = $urandom_range(0, 1) == 1;
      rd_en     = $urandom_range(0, 1) == 1;
      addr      = 3'($urandom_range(0, 7));
      wr_data   = W'($urandom);
      wr_mask   = W'($urandom);
      rx_active = $urandom_range(0, 1) == 1;
      tx_active = $urandom_range(0, 1) == 1;
      ext_in    = W'($urandom);
    end
    @(posedge clk); #2;
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule